// File: doc/BRIEF.md
# Tablet bottling count controller

This block sequences a tablet bottling line. A sensor strobe arrives for each tablet that drops. The block counts tablets into the current bottle, bottles into the current box, and boxes into the production run. When the last box of the run is full, it stops for good. A four-digit decimal tally of all tablets counted runs alongside.

The operator sets the number of tablets per bottle on a 4x4 matrix keypad. The two decimal digits of the fill count are entered one at a time. A select input chooses whether each digit lands in the tens place or the units place. A load key converts the two held digits to binary and stages the result. The staged value takes over only when the bottle being filled is finished, or at once if no tablet has entered the current bottle yet. A clear key wipes the held digits and cancels any staged value that has not yet taken effect.

Top module: `pill_line_ctrl`

## Requirements
- R1: Keypad codes are formed from one-hot row and one-hot column lines. For row r and column c with r and c both in 0..2, the key is digit 3r+c+1. Row 3, column 1 is digit 0. Row 0, column 3 is load. Row 3, column 3 is clear. Any other combination does nothing, including a line set that is not one-hot.
- R2: A digit key writes the tens place of the held entry when `tensSel` is 1, and the units place when `tensSel` is 0. The clear key sets both places to zero.
- R3: The load key stages the value 10*tens + units, and `presetBin` shows the active fill count in binary. All 100 entries from 00 to 99 convert correctly.
- R4: An active fill count of 0 stops tablet counting. With a count of 0, `tabletCount` stays 0 and no bottle or box pulse is produced.
- R5: A staged value becomes active only while `tabletCount` is 0, or on the tablet that finishes a bottle. A clear before that point cancels the staged value.
- R6: With an active fill count P, `tabletCount` steps from 0 to P-1 and then wraps to 0. `bottleFull` is high during the cycle of the tablet strobe that finishes the bottle.
- R7: `bottleCount` runs from 0 to 23. `boxFull` is high together with the bottle pulse that finishes the 24th bottle of a box.
- R8: The box pulse that finishes the 18th box sets `done`, leaves `boxCount` at 17, and returns the bottle and tablet counts to 0. While `done` is set, tablet strobes have no effect. Only reset clears `done`.
- R9: `totalBcd` holds four BCD digits, with the units digit in bits 3:0. Every tablet that is counted adds one to it, and it wraps from 9999 to 0.
- R10: Keys that are not assigned a function, and line sets that are not one-hot, leave the held entry, the staged value and the active fill count unchanged.
- R11: After reset, all counts, `presetBin`, `totalBcd` and `done` are 0, and the held entry is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tabletPulse | input | 1 | Single-cycle tablet strobe |
| rowLines | input | 4 | Keypad row lines, one-hot |
| colLines | input | 4 | Keypad column lines, one-hot |
| tensSel | input | 1 | Digit goes to tens place when 1 |
| presetBin | output | 8 | Active tablets-per-bottle count |
| tabletCount | output | 8 | Tablets in current bottle |
| bottleCount | output | 5 | Bottles in current box |
| boxCount | output | 5 | Boxes completed in this run |
| totalBcd | output | 16 | Decimal total of tablets counted |
| bottleFull | output | 1 | Bottle finished strobe |
| boxFull | output | 1 | Box finished strobe |
| done | output | 1 | Run complete, counting halted |

## Verification
The assertions check the following on every cycle:
- the tablet count stays below a nonzero fill count;
- with a zero fill count, nothing counts and no pulses appear;
- a box pulse appears only together with a bottle pulse;
- the fill count changes only at a bottle boundary;
- `done` is sticky and freezes the total;
- every total digit is a legal decimal digit.

Some behaviour can only be shown by the bench's scenarios:
- the conversion of all hundred keypad entries;
- the exact tablet on which each pulse and the final stop land;
- the decimal wrap past 9999;
- that a staged value is deferred or cancelled;
- that unassigned keys and line sets that are not one-hot leave the held entry and the staged value alone.

// File: rtl/pill_pkg.sv
package pill_pkg;

  typedef logic [3:0] keyCode_t;

  localparam keyCode_t KEY_LOAD  = 4'hA;
  localparam keyCode_t KEY_CLEAR = 4'hB;
  localparam keyCode_t KEY_SPARE = 4'hC;
  localparam keyCode_t KEY_NONE  = 4'hF;

  // strobes passed from keypad control to the counting datapath
  typedef struct packed {
    logic     digitWr;
    keyCode_t digitVal;
    logic     loadReq;
    logic     clearReq;
  } keyStrobe_t;

  // two BCD digits to binary: tens*8 + tens*2 + units
  function automatic logic [7:0] bcdToBin(input logic [7:0] bcd);
    logic [7:0] tens;
    logic [7:0] units;
    tens  = {4'b0, bcd[7:4]};
    units = {4'b0, bcd[3:0]};
    return (tens << 3) + (tens << 1) + units;
  endfunction

endpackage

// File: rtl/pill_keypad_ctl.sv
module pill_keypad_ctl
  import pill_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] rowLines,
  input  logic [3:0] colLines,
  output keyStrobe_t strb
);

  keyCode_t curCode;
  keyCode_t prevCode;
  logic     fresh;

  function automatic logic [1:0] oneHotIdx(input logic [3:0] v);
    logic [1:0] idx;
    idx = 2'd0;
    for (int i = 0; i < 4; i++) begin
      if (v[i]) idx = 2'(i);
    end
    return idx;
  endfunction

  function automatic keyCode_t decodeKey(input logic [3:0] row, input logic [3:0] col);
    logic [1:0] r;
    logic [1:0] c;
    keyCode_t   code;
    r = oneHotIdx(row);
    c = oneHotIdx(col);
    if (!$onehot(row) || !$onehot(col)) begin
      code = KEY_NONE;
    end else if (r != 2'd3 && c != 2'd3) begin
      code = keyCode_t'({2'b0, r} * 4'd3 + {2'b0, c} + 4'd1);
    end else if (r == 2'd3 && c == 2'd1) begin
      code = 4'd0;
    end else if (r == 2'd0 && c == 2'd3) begin
      code = KEY_LOAD;
    end else if (r == 2'd3 && c == 2'd3) begin
      code = KEY_CLEAR;
    end else begin
      code = KEY_SPARE;
    end
    return code;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      curCode  <= KEY_NONE;
      prevCode <= KEY_NONE;
    end else begin
      curCode  <= decodeKey(rowLines, colLines);
      prevCode <= curCode;
    end
  end

  // one action per press: act only on the first cycle of a new code
  assign fresh = (curCode != prevCode);

  always_comb begin
    strb.digitWr  = fresh && (curCode <= 4'd9);
    strb.digitVal = curCode;
    strb.loadReq  = fresh && (curCode == KEY_LOAD);
    strb.clearReq = fresh && (curCode == KEY_CLEAR);
  end

endmodule

// File: rtl/pill_bcd_total.sv
module pill_bcd_total #(
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  incr,
  output logic [4*DIGITS-1:0]   value
);

  logic [DIGITS:0] carry;

  assign carry[0] = incr;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] dig;
    assign carry[g+1] = carry[g] && (dig == 4'd9);
    always_ff @(posedge clk) begin
      if (rst) begin
        dig <= 4'd0;
      end else if (carry[g]) begin
        dig <= (dig == 4'd9) ? 4'd0 : dig + 4'd1;
      end
    end
    assign value[4*g +: 4] = dig;
  end

endmodule

// File: rtl/pill_count_path.sv
module pill_count_path
  import pill_pkg::*;
#(
  parameter int BOTTLES_PER_BOX = 24,
  parameter int BOXES_PER_RUN   = 18,
  parameter int TOTAL_DIGITS    = 4,
  parameter int BOTTLE_W        = $clog2(BOTTLES_PER_BOX),
  parameter int BOX_W           = $clog2(BOXES_PER_RUN)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  keyStrobe_t                strb,
  input  logic                      tensSel,
  input  logic                      tabletPulse,
  output logic [7:0]                presetBin,
  output logic [7:0]                tabletCount,
  output logic [BOTTLE_W-1:0]       bottleCount,
  output logic [BOX_W-1:0]          boxCount,
  output logic [4*TOTAL_DIGITS-1:0] totalBcd,
  output logic                      bottleFull,
  output logic                      boxFull,
  output logic                      done
);

  localparam logic [BOTTLE_W-1:0] LastBottle = BOTTLE_W'(BOTTLES_PER_BOX - 1);
  localparam logic [BOX_W-1:0]    LastBox    = BOX_W'(BOXES_PER_RUN - 1);

  logic [7:0] digitReg;
  logic [7:0] stagedVal;
  logic       stagedValid;
  logic       countTablet;
  logic       atLast;
  logic       takePreset;
  logic       runEnd;

  // held keypad entry
  always_ff @(posedge clk) begin
    if (rst) begin
      digitReg <= 8'h00;
    end else if (strb.clearReq) begin
      digitReg <= 8'h00;
    end else if (strb.digitWr) begin
      if (tensSel) digitReg[7:4] <= strb.digitVal;
      else         digitReg[3:0] <= strb.digitVal;
    end
  end

  assign countTablet = tabletPulse && !done && (presetBin != 8'd0);
  assign atLast      = (tabletCount == presetBin - 8'd1);
  assign bottleFull  = countTablet && atLast;
  assign boxFull     = bottleFull && (bottleCount == LastBottle);
  assign runEnd      = boxFull && (boxCount == LastBox);
  assign takePreset  = stagedValid &&
                       (((tabletCount == 8'd0) && !countTablet) || bottleFull);

  // staged value waits for a bottle boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      stagedVal   <= 8'd0;
      stagedValid <= 1'b0;
      presetBin   <= 8'd0;
    end else begin
      if (takePreset) begin
        presetBin   <= stagedVal;
        stagedValid <= 1'b0;
      end
      if (strb.clearReq) begin
        stagedValid <= 1'b0;
      end else if (strb.loadReq) begin
        stagedVal   <= bcdToBin(digitReg);
        stagedValid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tabletCount <= 8'd0;
      bottleCount <= '0;
      boxCount    <= '0;
      done        <= 1'b0;
    end else if (countTablet) begin
      tabletCount <= atLast ? 8'd0 : tabletCount + 8'd1;
      if (bottleFull) begin
        bottleCount <= (bottleCount == LastBottle) ? '0 : bottleCount + 1'b1;
      end
      if (boxFull) begin
        if (runEnd) done <= 1'b1;
        else        boxCount <= boxCount + 1'b1;
      end
    end
  end

  pill_bcd_total #(.DIGITS(TOTAL_DIGITS)) u_total (
    .clk  (clk),
    .rst  (rst),
    .incr (countTablet),
    .value(totalBcd)
  );

endmodule

// File: rtl/pill_line_ctrl.sv
module pill_line_ctrl
  import pill_pkg::*;
#(
  parameter int BOTTLES_PER_BOX = 24,
  parameter int BOXES_PER_RUN   = 18,
  parameter int TOTAL_DIGITS    = 4,
  parameter int BOTTLE_W        = $clog2(BOTTLES_PER_BOX),
  parameter int BOX_W           = $clog2(BOXES_PER_RUN)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tabletPulse,
  input  logic [3:0]                rowLines,
  input  logic [3:0]                colLines,
  input  logic                      tensSel,
  output logic [7:0]                presetBin,
  output logic [7:0]                tabletCount,
  output logic [BOTTLE_W-1:0]       bottleCount,
  output logic [BOX_W-1:0]          boxCount,
  output logic [4*TOTAL_DIGITS-1:0] totalBcd,
  output logic                      bottleFull,
  output logic                      boxFull,
  output logic                      done
);

  keyStrobe_t keyStrb;

  pill_keypad_ctl u_keys (
    .clk     (clk),
    .rst     (rst),
    .rowLines(rowLines),
    .colLines(colLines),
    .strb    (keyStrb)
  );

  pill_count_path #(
    .BOTTLES_PER_BOX(BOTTLES_PER_BOX),
    .BOXES_PER_RUN  (BOXES_PER_RUN),
    .TOTAL_DIGITS   (TOTAL_DIGITS),
    .BOTTLE_W       (BOTTLE_W),
    .BOX_W          (BOX_W)
  ) u_path (
    .clk        (clk),
    .rst        (rst),
    .strb       (keyStrb),
    .tensSel    (tensSel),
    .tabletPulse(tabletPulse),
    .presetBin  (presetBin),
    .tabletCount(tabletCount),
    .bottleCount(bottleCount),
    .boxCount   (boxCount),
    .totalBcd   (totalBcd),
    .bottleFull (bottleFull),
    .boxFull    (boxFull),
    .done       (done)
  );

endmodule

// File: rtl/pill_line_chk.sv
module pill_line_chk #(
  parameter int BOTTLES_PER_BOX = 24,
  parameter int BOXES_PER_RUN   = 18,
  parameter int TOTAL_DIGITS    = 4,
  parameter int BOTTLE_W        = $clog2(BOTTLES_PER_BOX),
  parameter int BOX_W           = $clog2(BOXES_PER_RUN)
) (
  input logic                      clk,
  input logic                      rst,
  input logic [7:0]                presetBin,
  input logic [7:0]                tabletCount,
  input logic [BOTTLE_W-1:0]       bottleCount,
  input logic [BOX_W-1:0]          boxCount,
  input logic [4*TOTAL_DIGITS-1:0] totalBcd,
  input logic                      bottleFull,
  input logic                      boxFull,
  input logic                      done
);

  function automatic logic digitsLegal(input logic [4*TOTAL_DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < TOTAL_DIGITS; i++) begin
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  p_count_below_preset_r6: assert property (@(posedge clk) disable iff (rst)
    (presetBin != 8'd0) |-> (tabletCount < presetBin));

  p_zero_preset_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (presetBin == 8'd0) |-> (!bottleFull && !boxFull && tabletCount == 8'd0));

  p_box_with_bottle_r7: assert property (@(posedge clk) disable iff (rst)
    boxFull |-> bottleFull);

  p_bottle_range_r7: assert property (@(posedge clk) disable iff (rst)
    (bottleCount < BOTTLE_W'(BOTTLES_PER_BOX)) && (boxCount < BOX_W'(BOXES_PER_RUN)));

  p_preset_at_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(presetBin) |-> (tabletCount == 8'd0));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_done_freezes_total_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(totalBcd) && !bottleFull));

  p_total_digits_r9: assert property (@(posedge clk) disable iff (rst)
    digitsLegal(totalBcd));

endmodule

bind pill_line_ctrl pill_line_chk #(
  .BOTTLES_PER_BOX(BOTTLES_PER_BOX),
  .BOXES_PER_RUN  (BOXES_PER_RUN),
  .TOTAL_DIGITS   (TOTAL_DIGITS),
  .BOTTLE_W       (BOTTLE_W),
  .BOX_W          (BOX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .presetBin  (presetBin),
  .tabletCount(tabletCount),
  .bottleCount(bottleCount),
  .boxCount   (boxCount),
  .totalBcd   (totalBcd),
  .bottleFull (bottleFull),
  .boxFull    (boxFull),
  .done       (done)
);

// File: tb/pill_line_ctrl_bench.sv
`timescale 1ns/1ps
module pill_line_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tabletPulse = 1'b0;
  logic [3:0]  rowLines = 4'b0;
  logic [3:0]  colLines = 4'b0;
  logic        tensSel = 1'b0;
  logic [7:0]  presetBin;
  logic [7:0]  tabletCount;
  logic [4:0]  bottleCount;
  logic [4:0]  boxCount;
  logic [15:0] totalBcd;
  logic        bottleFull;
  logic        boxFull;
  logic        done;

  int total = 0;
  int bad = 0;
  logic seenBottle;
  logic seenBox;

  always #5 clk = ~clk;

  pill_line_ctrl u_pill_line_ctrl (
    .clk(clk), .rst(rst), .tabletPulse(tabletPulse),
    .rowLines(rowLines), .colLines(colLines), .tensSel(tensSel),
    .presetBin(presetBin), .tabletCount(tabletCount),
    .bottleCount(bottleCount), .boxCount(boxCount), .totalBcd(totalBcd),
    .bottleFull(bottleFull), .boxFull(boxFull), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int toBcd(input int n);
    int m;
    m = n % 10000;
    return ((m / 1000) << 12) | (((m / 100) % 10) << 8) | (((m / 10) % 10) << 4) | (m % 10);
  endfunction

  task automatic pressRaw(input logic [3:0] r, input logic [3:0] c);
    @(posedge clk); #1;
    rowLines = r; colLines = c;
    repeat (2) @(posedge clk);
    #1 rowLines = 4'b0; colLines = 4'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic pressAt(input int r, input int c);
    pressRaw(4'(1 << r), 4'(1 << c));
  endtask

  task automatic pressDigit(input int d, input bit tens);
    @(posedge clk); #1 tensSel = tens;
    if (d == 0) pressAt(3, 1);
    else pressAt((d - 1) / 3, (d - 1) % 3);
  endtask

  task automatic enterAndLoad(input int v);
    pressDigit(v / 10, 1'b1);
    pressDigit(v % 10, 1'b0);
    pressAt(0, 3);
  endtask

  task automatic tablet();
    @(posedge clk); #1 tabletPulse = 1'b1;
    @(negedge clk);
    seenBottle = bottleFull;
    seenBox = boxFull;
    @(posedge clk); #1 tabletPulse = 1'b0;
  endtask

  task automatic doReset();
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic fullRun(input int p, input string tag);
    int runLen;
    runLen = 18 * 24 * p;
    for (int n = 1; n <= runLen; n++) begin
      if (n == runLen) begin
        @(negedge clk);
        check(done == 1'b0, "R8 done before last tablet", done, 0);
      end
      tablet();
      check(seenBottle == ((n % p) == 0), {tag, " R6 bottleFull"}, seenBottle, (n % p) == 0);
      check(seenBox == ((n % (24 * p)) == 0), {tag, " R7 boxFull"}, seenBox, (n % (24 * p)) == 0);
    end
    @(negedge clk);
    check(done == 1'b1, "R8 done after last box", done, 1);
    check(boxCount == 5'd17, "R8 boxCount holds", boxCount, 17);
    check(bottleCount == 5'd0 && tabletCount == 8'd0, "R8 counts back to 0",
          bottleCount + tabletCount, 0);
    check(totalBcd == 16'(toBcd(runLen)), "R9 total after run", totalBcd, toBcd(runLen));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R11 reset state
    check(presetBin == 0 && tabletCount == 0 && bottleCount == 0 && boxCount == 0,
          "R11 counts after reset", presetBin + tabletCount, 0);
    check(totalBcd == 0 && done == 0, "R11 total/done after reset", totalBcd, 0);
    pressAt(0, 3);
    @(negedge clk);
    check(presetBin == 0, "R11 held entry is 00", presetBin, 0);

    // R1 R2 R3 exhaustive entry sweep
    for (int v = 0; v < 100; v++) begin
      enterAndLoad(v);
      @(negedge clk);
      check(presetBin == 8'(v), "R3 R1 R2 conversion", presetBin, v);
    end

    // R4 zero preset
    enterAndLoad(0);
    @(negedge clk);
    check(presetBin == 0, "R4 zero loaded", presetBin, 0);
    for (int k = 0; k < 3; k++) begin
      tablet();
      check(!seenBottle, "R4 no pulse", seenBottle, 0);
    end
    @(negedge clk);
    check(tabletCount == 0 && totalBcd == 0, "R4 no counting", tabletCount + totalBcd, 0);

    // R5 deferred load
    enterAndLoad(5);
    tablet(); tablet();
    enterAndLoad(3);
    @(negedge clk);
    check(presetBin == 5, "R5 deferred mid-bottle", presetBin, 5);
    tablet(); tablet();
    check(!seenBottle, "R6 no early pulse", seenBottle, 0);
    tablet();
    check(seenBottle, "R6 fifth tablet fills", seenBottle, 1);
    @(negedge clk);
    check(presetBin == 3, "R5 takes effect at boundary", presetBin, 3);
    check(totalBcd == 16'h0005, "R9 total counts", totalBcd, 5);

    // R5 clear cancels staged value
    tablet();
    enterAndLoad(7);
    pressAt(3, 3);
    tablet(); tablet();
    check(seenBottle, "R5 bottle with old preset", seenBottle, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(presetBin == 3, "R5 cancelled by clear", presetBin, 3);

    // R2 clear zeroes the held entry
    pressDigit(4, 1'b1);
    pressDigit(7, 1'b0);
    pressAt(3, 3);
    pressAt(0, 3);
    @(negedge clk);
    check(presetBin == 0, "R2 clear zeroes digits", presetBin, 0);

    // R10 spare keys and line sets that are not one-hot
    enterAndLoad(12);
    pressAt(1, 3); pressAt(2, 3); pressAt(3, 0); pressAt(3, 2);
    pressRaw(4'b0011, 4'b0001);
    pressRaw(4'b0001, 4'b0110);
    @(negedge clk);
    check(presetBin == 12, "R10 spares keep preset", presetBin, 12);
    pressAt(0, 3);
    @(negedge clk);
    check(presetBin == 12, "R10 held entry intact", presetBin, 12);

    // R6 R7 R8 full run with fill count 2
    doReset();
    enterAndLoad(2);
    fullRun(2, "P2");
    for (int k = 0; k < 3; k++) tablet();
    @(negedge clk);
    check(totalBcd == 16'h0864 && tabletCount == 0, "R8 halted after done", totalBcd, 16'h0864);

    // R9 wrap past 9999
    doReset();
    enterAndLoad(25);
    fullRun(25, "P25");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule